// File: doc/BRIEF.md
# Inverse Square Root Seed Generator

This block turns the significand of a normalised floating-point operand, X = 1.f, into a first approximation R of 1/√X. A later refinement step can then reach full precision from this seed. The block uses one small coefficient table and one multiply, so it does not need a large direct lookup.

The top fraction bits of X, together with the exponent parity, select a coefficient C from a table. The table is computed when the design is elaborated. The next fraction bits are rearranged and partly inverted to form a modified operand X'. A multiplier that drops its lowest partial-product columns and adds a fixed bias then forms R = X'·C.

The unit is a two-stage pipeline. It accepts one operand per cycle, and each result appears two cycles after its operand. When the exponent parity bit is set, the result is scaled by 1/√2. The surrounding exponent logic can then halve an even exponent.

Top module: `isr_seed_gen`

## Requirements
- R1: While reset is held and in the first two cycles after it, `out_valid` is 0. Directly after reset, `out_r` is 0.
- R2: An operand accepted with `in_valid`=1 at a rising edge produces `out_valid`=1 after exactly the second rising edge that follows. A cycle without `in_valid` produces `out_valid`=0 at the same distance. One operand can be accepted on every cycle.
- R3: In a cycle where `out_valid` is 0, `out_r` keeps the value of the previous result.
- R4: With `in_exp_lsb`=0, the value of `out_r` is within 2^-(2M+1) of 1/√X. Here X = 1 + in_frac·2^-FW and `out_r` is read as an unsigned fixed-point number with 1 integer bit and RF fraction bits.
- R5: With `in_exp_lsb`=1, the value of `out_r` is within 2^-(2M+1) of 1/√(2X).
- R6: The modified operand has one integer bit, which is 1, and NX fraction bits. Numbering the fraction bits x1 (the MSB of `in_frac`) downwards, the fraction bits are, in order: x1..xM, then the inverse of x(M+1), then x(M+1) itself, then the inverses of x(M+2)..x(NX-1).
- R7: The table address is {x1..xM, in_exp_lsb}. With X1 = 1.x1..xM, the entry is X1^(-3/2) − 3·2^(−M−2)·X1^(−5/2) + 33·2^(−2M−6)·X1^(−7/2). The entry is multiplied by 1/√2 when the parity bit is 1, then rounded to nearest with CW fraction bits.
- R8: `out_r` is within 2 units of its last place (2^-RF) of the exact product of the modified operand and the table entry.
- R9: The fraction bits below x(NX-1), that is `in_frac[FW-NX:0]`, have no effect on `out_r`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_frac | input | FW | Fraction bits of X; the MSB is x1 |
| in_exp_lsb | input | 1 | Exponent parity; 1 selects the 1/√2-scaled table half |
| out_valid | output | 1 | Result present this cycle |
| out_r | output | RF+1 | Seed R: 1 integer bit and RF fraction bits |

## Verification
Every result is due two rising edges after its operand is accepted, and the bubble marker is due at the same distance. The bench drives inputs and samples outputs on falling edges. At each falling edge it compares the outputs with the operand it drove two falling edges earlier, which it keeps in a two-entry history. In bubble cycles the same history tells the bench that `out_valid` must be 0 and that `out_r` must still equal the last result seen.

// File: rtl/isr_pkg.sv
`timescale 1ns/1ps
package isr_pkg;

  // Fixed-point scale used while building table entries at elaboration time
  localparam int SCALE_BITS = 28;

  // Floor of the square root of a 64-bit value, one result bit per step
  function automatic longint unsigned isqrt_u64(input longint unsigned v);
    longint unsigned rem;
    longint unsigned res;
    longint unsigned trial;
    rem = v;
    res = 64'd0;
    for (int i = 31; i >= 0; i--) begin
      trial = (res << (i + 1)) + (64'd1 << (2 * i));
      if (rem >= trial) begin
        rem = rem - trial;
        res = res | (64'd1 << i);
      end
    end
    return res;
  endfunction

  // Table entry for upper-fraction index hi_idx and exponent parity odd,
  // rounded to nearest with cw fraction bits (M up to 7)
  function automatic longint unsigned coef_calc(input int m, input int cw,
                                                input int hi_idx, input bit odd);
    longint unsigned den;
    longint unsigned root;
    longint unsigned inv;
    longint unsigned p3;
    longint unsigned p5;
    longint unsigned p7;
    longint unsigned acc;
    den  = (64'd1 << m) + longint'(hi_idx);
    root = isqrt_u64((64'd1 << (m + 2 * SCALE_BITS)) / den);   // X1^-1/2
    inv  = (64'd1 << (m + SCALE_BITS)) / den;                   // X1^-1
    p3   = (root * inv) >> SCALE_BITS;
    p5   = (p3 * inv) >> SCALE_BITS;
    p7   = (p5 * inv) >> SCALE_BITS;
    acc  = p3 - ((64'd3 * p5) >> (m + 2)) + ((64'd33 * p7) >> (2 * m + 6));
    if (odd)
      acc = (acc * isqrt_u64(64'd1 << (2 * SCALE_BITS - 1))) >> SCALE_BITS;
    acc = (acc + (64'd1 << (SCALE_BITS - cw - 1))) >> (SCALE_BITS - cw);
    return acc;
  endfunction

endpackage

// File: rtl/isr_coef_rom.sv
`timescale 1ns/1ps
module isr_coef_rom #(
  parameter int M  = 4,
  parameter int CW = 14
) (
  input  logic [M:0]    addr,
  output logic [CW-1:0] coef
);
  localparam int ENTRIES = 2 ** (M + 1);

  logic [CW-1:0] tbl [ENTRIES];

  // Address LSB is the exponent parity, the rest is x1..xM
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    localparam logic [CW-1:0] ENTRY =
      CW'(isr_pkg::coef_calc(M, CW, g / 2, (g % 2) == 1));
    assign tbl[g] = ENTRY;
  end

  assign coef = tbl[addr];
endmodule

// File: rtl/isr_operand_mod.sv
`timescale 1ns/1ps
module isr_operand_mod #(
  parameter int FW = 23,
  parameter int M  = 4,
  parameter int NX = 12
) (
  input  logic [FW-1:0] frac,
  output logic [NX:0]   xmod
);
  localparam int LOW_W = NX - M - 2;   // inverted tail width

  function automatic logic [NX:0] modify(input logic [FW-1:0] f);
    logic split_bit;
    split_bit = f[FW-M-1];
    return {1'b1, f[FW-1 -: M], ~split_bit, split_bit, ~f[FW-M-2 -: LOW_W]};
  endfunction

  assign xmod = modify(frac);

  logic unused_low;
  assign unused_low = ^frac[FW-NX:0];
endmodule

// File: rtl/isr_trunc_mul.sv
`timescale 1ns/1ps
module isr_trunc_mul #(
  parameter int AW   = 13,
  parameter int BW   = 14,
  parameter int RW   = 15,
  parameter int KEEP = 4
) (
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [RW-1:0] p
);
  localparam int PW   = AW + BW;
  localparam int DROP = PW - RW;
  localparam int CUT  = DROP - KEEP;
  localparam logic [PW-1:0] COL_MASK = ~((PW'(1) << CUT) - PW'(1));
  localparam logic [PW-1:0] BIAS     = PW'(1) << (DROP - 1);

  logic [PW-1:0] row [AW];
  logic [PW-1:0] acc;

  // Each row keeps only the columns at or above CUT
  for (genvar j = 0; j < AW; j++) begin : g_row
    assign row[j] = a[j] ? ((PW'(b) << j) & COL_MASK) : '0;
  end

  always_comb begin
    acc = BIAS;
    for (int j = 0; j < AW; j++) acc = acc + row[j];
  end

  assign p = acc[PW-1:DROP];

  logic unused_tail;
  assign unused_tail = ^acc[DROP-1:0];
endmodule

// File: rtl/isr_seed_gen.sv
`timescale 1ns/1ps
module isr_seed_gen #(
  parameter int FW   = 23,
  parameter int M    = 4,
  parameter int NX   = 12,
  parameter int CW   = 14,
  parameter int RF   = 14,
  parameter int KEEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [FW-1:0] in_frac,
  input  logic          in_exp_lsb,
  output logic          out_valid,
  output logic [RF:0]   out_r
);
  localparam int AW = NX + 1;
  localparam int RW = RF + 1;

  // Stage 0 combinational: table address, coefficient, modified operand
  logic [M:0]    rom_addr;
  logic [CW-1:0] coef_now;
  logic [AW-1:0] xmod_now;

  assign rom_addr = {in_frac[FW-1 -: M], in_exp_lsb};

  isr_coef_rom #(.M(M), .CW(CW)) u_rom (
    .addr (rom_addr),
    .coef (coef_now)
  );

  isr_operand_mod #(.FW(FW), .M(M), .NX(NX)) u_mod (
    .frac (in_frac),
    .xmod (xmod_now)
  );

  // Stage 1 registers
  logic          s1_valid;
  logic          s1_odd;
  logic [CW-1:0] s1_coef;
  logic [AW-1:0] s1_xmod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_odd   <= 1'b0;
      s1_coef  <= '0;
      s1_xmod  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_odd  <= in_exp_lsb;
        s1_coef <= coef_now;
        s1_xmod <= xmod_now;
      end
    end
  end

  // Stage 2: truncated multiply and result register
  logic [RW-1:0] prod;

  isr_trunc_mul #(.AW(AW), .BW(CW), .RW(RW), .KEEP(KEEP)) u_mul (
    .a (s1_xmod),
    .b (s1_coef),
    .p (prod)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_r     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_r <= prod;
    end
  end
endmodule

// File: rtl/isr_seed_gen_chk.sv
`timescale 1ns/1ps
module isr_seed_gen_chk #(
  parameter int M  = 4,
  parameter int NX = 12,
  parameter int CW = 14,
  parameter int RF = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [RF:0]   out_r,
  input logic          s1_valid,
  input logic          s1_odd,
  input logic [CW-1:0] s1_coef,
  input logic [NX:0]   s1_xmod
);
  // Cycles since reset release, saturating at 3
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  localparam logic [RF:0]   R_LO     = (RF+1)'((2 ** RF) * 29 / 100);
  localparam logic [RF:0]   R_HI     = (RF+1)'((2 ** RF) * 103 / 100);
  localparam logic [CW-1:0] ODD_MAX  = CW'((2 ** CW) * 69 / 100);
  localparam logic [CW-1:0] EVEN_MIN = CW'((2 ** CW) * 36 / 100);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (warm < 2'd2) |-> !out_valid);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  a_r3_hold_on_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && !$past(in_valid, 2)) |-> $stable(out_r));

  a_r4_out_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_r >= R_LO && out_r <= R_HI));

  a_r5_odd_coef_scaled: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_odd) |-> (s1_coef <= ODD_MAX));

  a_r7_even_coef_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_odd) |-> (s1_coef >= EVEN_MIN));

  a_r6_operand_shape: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (s1_xmod[NX] && (s1_xmod[NX-M-1] != s1_xmod[NX-M-2])));
endmodule

bind isr_seed_gen isr_seed_gen_chk #(.M(M), .NX(NX), .CW(CW), .RF(RF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_r     (out_r),
  .s1_valid  (s1_valid),
  .s1_odd    (s1_odd),
  .s1_coef   (s1_coef),
  .s1_xmod   (s1_xmod)
);

// File: tb/isr_seed_gen_bench.sv
`timescale 1ns/1ps
module isr_seed_gen_bench;
  localparam int FW = 23;
  localparam int M  = 4;
  localparam int NX = 12;
  localparam int CW = 14;
  localparam int RF = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [FW-1:0] in_frac = '0;
  logic          in_exp_lsb = 1'b0;
  logic          out_valid;
  logic [RF:0]   out_r;

  isr_seed_gen #(.FW(FW), .M(M), .NX(NX), .CW(CW), .RF(RF)) u_isr_seed_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frac(in_frac),
    .in_exp_lsb(in_exp_lsb), .out_valid(out_valid), .out_r(out_r)
  );

  always #2.5 clk = ~clk;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  // Input history: h0 driven one falling edge ago, h1 two ago
  bit            h0_v = 0, h1_v = 0;
  logic [FW-1:0] h0_f = '0, h1_f = '0;
  bit            h0_e = 0, h1_e = 0;
  logic [RF:0]   held_r = '0, last_r = '0, prev_r = '0;

  task automatic chk_int(input bit ok, input string req, input longint got, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_real(input bit ok, input string req, input real got, input real exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %f expected %f", req, got, exp);
    end
  endtask

  function automatic real x_of(input logic [FW-1:0] f);
    return 1.0 + real'(f) / (2.0 ** FW);
  endfunction

  // R4/R5 reference
  function automatic real inv_root(input logic [FW-1:0] f, input bit e);
    real r;
    r = 1.0 / $sqrt(x_of(f));
    if (e) r = r / $sqrt(2.0);
    return r;
  endfunction

  // R7 reference entry from its formula, in real arithmetic
  function automatic real coef_ref(input logic [FW-1:0] f, input bit e);
    real x1, s, c;
    x1 = 1.0 + real'(f >> (FW - M)) / (2.0 ** M);
    s  = $sqrt(x1);
    c  = 1.0 / (x1 * s)
       - 3.0 * (2.0 ** (-M - 2)) / (x1 * x1 * s)
       + 33.0 * (2.0 ** (-2 * M - 6)) / (x1 * x1 * x1 * s);
    if (e) c = c * $sqrt(0.5);
    return $floor(c * (2.0 ** CW) + 0.5) / (2.0 ** CW);
  endfunction

  // R6 reference: walk the fraction positions one by one
  function automatic real xmod_ref(input logic [FW-1:0] f);
    longint acc;
    bit b;
    acc = 0;
    for (int pos = 1; pos <= NX; pos++) begin
      if (pos <= M)           b = f[FW - pos];
      else if (pos == M + 1)  b = !f[FW - M - 1];
      else if (pos == M + 2)  b = f[FW - M - 1];
      else                    b = !f[FW - pos + 1];
      acc = acc * 2 + longint'(b);
    end
    return 1.0 + real'(acc) / (2.0 ** NX);
  endfunction

  task automatic check_out();
    real got, ref_v, prod;
    if (h1_v) begin
      chk_int(out_valid == 1'b1, "R2 result valid two cycles after input", out_valid, 1);
      got   = real'(out_r) / (2.0 ** RF);
      ref_v = inv_root(h1_f, h1_e);
      if (h1_e)
        chk_real((got - ref_v) <= 2.0 ** (-(2*M+1)) && (ref_v - got) <= 2.0 ** (-(2*M+1)),
                 "R5 odd-parity seed vs 1/sqrt(2X)", got, ref_v);
      else
        chk_real((got - ref_v) <= 2.0 ** (-(2*M+1)) && (ref_v - got) <= 2.0 ** (-(2*M+1)),
                 "R4 even-parity seed vs 1/sqrt(X)", got, ref_v);
      prod = xmod_ref(h1_f) * coef_ref(h1_f, h1_e);
      chk_real((got - prod) <= 2.0 * (2.0 ** (-RF)) && (prod - got) <= 2.0 * (2.0 ** (-RF)),
               "R6/R7/R8 seed vs modified operand times entry", got, prod);
      prev_r = last_r;
      last_r = out_r;
      held_r = out_r;
    end else begin
      chk_int(out_valid == 1'b0, "R2 no result for a bubble", out_valid, 0);
      chk_int(out_r == held_r, "R3 result held in bubble", out_r, held_r);
    end
  endtask

  task automatic step(input bit v, input logic [FW-1:0] f, input bit e);
    check_out();
    in_valid   = v;
    in_frac    = f;
    in_exp_lsb = e;
    h1_v = h0_v; h1_f = h0_f; h1_e = h0_e;
    h0_v = v;    h0_f = f;    h0_e = e;
    @(negedge clk);
  endtask

  localparam logic [FW-1:0] ALL1 = '1;

  initial begin
    void'($urandom(32'h1D5EED));
    repeat (3) @(negedge clk);
    chk_int(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    chk_int(out_r == '0, "R1 reset result", out_r, 0);
    rst_n = 1'b1;
    step(0, '0, 0);
    step(0, '0, 0);
    chk_int(out_valid == 1'b0, "R1 quiet after reset", out_valid, 0);

    // Directed corners: both ends of the range, both parities, split boundaries
    step(1, '0, 0);
    step(1, '0, 1);
    step(1, ALL1, 0);
    step(1, ALL1, 1);
    step(1, FW'(1) << (FW - 1), 0);
    step(1, FW'(1) << (FW - M - 1), 1);
    step(1, (ALL1 >> M), 0);
    step(0, '0, 0);
    step(1, ALL1 << (FW - M), 1);
    step(0, '0, 0);
    step(0, '0, 0);

    // R9: same upper bits, different ignored low bits, back to back
    step(1, 23'h5A3000, 0);
    step(1, 23'h5A3FFF, 0);
    step(0, '0, 0);
    step(0, '0, 0);
    chk_int(last_r == prev_r, "R9 low fraction bits ignored", last_r, prev_r);
    step(1, 23'h2C7123, 1);
    step(1, 23'h2C7E9C, 1);
    step(0, '0, 0);
    step(0, '0, 0);
    chk_int(last_r == prev_r, "R9 low fraction bits ignored (odd)", last_r, prev_r);

    // Random stream with bubbles
    for (int i = 0; i < 3000; i++) begin
      bit v;
      v = ($urandom % 6) != 0;
      step(v, FW'($urandom), 1'($urandom));
    end
    step(0, '0, 0);
    step(0, '0, 0);
    step(0, '0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule